// File: doc/BRIEF.md
# Slave Transfer Pacing Unit

This block decides the clock cycles in which one data word moves between a word buffer and an attached slave device. Four pacing sources are available. A reload down-counter can tick at a programmed rate. The edges of an external clock can drive transfers, which lets two units run in lockstep. The slave can request each word itself. Or the unit can poll a slave status flag and transfer whenever that flag reports ready. Each transfer produces a single-cycle strobe toward the buffer and a matching strobe toward the slave.

For low-rate multichannel acquisition, the unit keeps a channel index that steps after every transfer. In the input direction it tags each captured sample with that index. In the output direction it splits a tagged word into a channel select and a zero-extended sample. Configuration is captured by a single load pulse. The load also restarts the rate counter, the poll sequence and the channel index, and clears the sticky error flag. If a pacing event finds the buffer unable to supply or accept a word, the event is dropped and the error flag is set.

Top module: `xferPacer`

## Requirements
- R1: In timer mode (cfgMode = 0) with divisor D, bufXfer first rises for one cycle D+2 clock edges after the edge that captures cfgLoad. It then pulses every D+1 cycles.
- R2: In external-clock mode (cfgMode = 1), each rising edge of extClk causes exactly one transfer. bufXfer is high after the third clock edge that follows the rising level first being presented. slvReq and slvStatus have no effect in this mode.
- R3: In slave-demand mode (cfgMode = 2), each rising edge of slvReq causes exactly one transfer, with the same three-edge latency as R2. extClk has no effect in this mode.
- R4: In polled mode (cfgMode = 3), slvPoll is high in the cycle after the load edge and then in every second cycle. slvStatus is sampled in the cycle that follows each poll cycle, and a high value gives a transfer at the next edge.
- R5: A pacing event that arrives while bufReady is low causes no transfer and sets errFlag. errFlag stays set until the next cfgLoad.
- R6: For a multichannel input transfer (cfgMulti = 1, cfgDirIn = 1), bufWrData carries the current channel index in bits 15:12 and slvRdData[11:0] in bits 11:0. slvChan shows the same index.
- R7: For a multichannel output transfer (cfgMulti = 1, cfgDirIn = 0), slvChan is taken from bufRdData[15:12] and slvWrData is bufRdData[11:0] zero-extended to 16 bits.
- R8: The channel index starts at 0 after cfgLoad, advances after each transfer, and wraps to 0 after reaching count−1. A count of 0 acts as 1, and a count above 16 acts as 16.
- R9: With cfgMulti = 0, all 16 bits pass unchanged (slvRdData to bufWrData, or bufRdData to slvWrData) and slvChan is 0.
- R10: After reset, and until the first cfgLoad, no transfer and no poll occur and errFlag is 0. In the cycle after any cfgLoad, bufXfer and errFlag are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | One-cycle pulse that captures the configuration |
| cfgMode | input | 2 | Pacing source: 0 timer, 1 external clock, 2 slave demand, 3 polled |
| cfgDivisor | input | DIV_W | Timer reload value D (period D+1 cycles) |
| cfgChanCount | input | CHAN_W+1 | Number of channels scanned in multichannel mode |
| cfgMulti | input | 1 | Enables channel tagging and stepping |
| cfgDirIn | input | 1 | 1: slave to buffer, 0: buffer to slave |
| extClk | input | 1 | Asynchronous external pacing clock |
| slvReq | input | 1 | Asynchronous slave transfer request |
| slvStatus | input | 1 | Slave ready status, valid in the cycle after slvPoll |
| slvPoll | output | 1 | Status read strobe toward the slave |
| bufReady | input | 1 | Buffer can supply or accept a word this cycle |
| bufRdData | input | WORD_W | Word from the buffer (output direction) |
| bufXfer | output | 1 | One-cycle transfer strobe toward the buffer |
| bufWrData | output | WORD_W | Word toward the buffer (input direction) |
| slvRdData | input | WORD_W | Data from the slave |
| slvWrData | output | WORD_W | Data toward the slave |
| slvChan | output | CHAN_W | Channel select toward the slave |
| slvStrobe | output | 1 | One-cycle transfer strobe toward the slave |
| errFlag | output | 1 | Sticky dropped-event flag |

## Verification
The bench targets exact strobe placement: the first timer tick (an off-by-one counter would shift every strobe by a cycle), the three-edge synchroniser latency, and the alternating poll/sample phases. A wrong phase would either transfer on a stale status bit or poll twice in a row. It cross-drives the unselected pacing inputs, so a mode decoder that leaks other sources shows up as extra strobes. Channel wrap is exercised at 16 channels and with the out-of-range counts 0 and 31. A bad clamp would emit indices beyond the programmed count. A random bufReady pattern drops events, and the bench checks that no strobe escapes when the buffer is not ready and that the sticky flag neither clears early nor survives a reload.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  typedef enum logic [1:0] {
    PACE_TIMER  = 2'd0,
    PACE_EXT    = 2'd1,
    PACE_DEMAND = 2'd2,
    PACE_POLL   = 2'd3
  } paceMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic fire;   // event accepted, move one word
    logic drop;   // event lost, buffer not ready
  } paceStrobe_t;

endpackage

// File: rtl/pacerEdgeSync.sv
module pacerEdgeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[STAGES-1:0], din};
  end

  assign rise = shiftQ[STAGES-1] & ~shiftQ[STAGES];
endmodule

// File: rtl/pacerCtl.sv
module pacerCtl
  import pacer_pkg::*;
#(
  parameter int DIV_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [1:0]       cfgMode,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic             extClk,
  input  logic             slvReq,
  input  logic             slvStatus,
  input  logic             bufReady,
  output logic             slvPoll,
  output paceStrobe_t      strobe
);
  localparam int N_ASYNC = 2;   // index 0: external clock, 1: slave request

  logic [N_ASYNC-1:0] asyncIn;
  logic [N_ASYNC-1:0] asyncRise;
  assign asyncIn = {slvReq, extClk};

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    pacerEdgeSync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (asyncIn[g]),
      .rise(asyncRise[g])
    );
  end

  logic             activeQ;
  paceMode_e        modeQ;
  logic [DIV_W-1:0] divisorQ;
  logic [DIV_W-1:0] countQ;
  logic             tickQ;
  logic             phaseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      modeQ    <= PACE_TIMER;
      divisorQ <= '0;
      countQ   <= '0;
      tickQ    <= 1'b0;
      phaseQ   <= 1'b0;
    end else if (cfgLoad) begin
      activeQ  <= 1'b1;
      modeQ    <= paceMode_e'(cfgMode);
      divisorQ <= cfgDivisor;
      countQ   <= cfgDivisor;
      tickQ    <= 1'b0;
      phaseQ   <= 1'b0;
    end else if (activeQ) begin
      if (modeQ == PACE_TIMER) begin
        if (countQ == '0) begin
          countQ <= divisorQ;
          tickQ  <= 1'b1;
        end else begin
          countQ <= countQ - 1'b1;
          tickQ  <= 1'b0;
        end
      end
      if (modeQ == PACE_POLL) phaseQ <= ~phaseQ;
    end
  end

  logic paceEvt;
  always_comb begin
    paceEvt = 1'b0;
    if (activeQ && !cfgLoad) begin
      unique case (modeQ)
        PACE_TIMER:  paceEvt = tickQ;
        PACE_EXT:    paceEvt = asyncRise[0];
        PACE_DEMAND: paceEvt = asyncRise[1];
        PACE_POLL:   paceEvt = phaseQ & slvStatus;
        default:     paceEvt = 1'b0;
      endcase
    end
  end

  assign slvPoll     = activeQ && (modeQ == PACE_POLL) && !phaseQ;
  assign strobe.fire = paceEvt & bufReady;
  assign strobe.drop = paceEvt & ~bufReady;
endmodule

// File: rtl/pacerDp.sv
module pacerDp
  import pacer_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int SAMPLE_W = 12,
  parameter int CHAN_W   = WORD_W - SAMPLE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              cfgMulti,
  input  logic              cfgDirIn,
  input  logic [CHAN_W:0]   cfgChanCount,
  input  paceStrobe_t       strobe,
  input  logic [WORD_W-1:0] bufRdData,
  input  logic [WORD_W-1:0] slvRdData,
  output logic              bufXfer,
  output logic [WORD_W-1:0] bufWrData,
  output logic              slvStrobe,
  output logic [WORD_W-1:0] slvWrData,
  output logic [CHAN_W-1:0] slvChan,
  output logic              errFlag
);
  localparam int MAX_CH = 1 << CHAN_W;

  logic              multiQ;
  logic              dirInQ;
  logic [CHAN_W-1:0] lastQ;
  logic [CHAN_W-1:0] indexQ;
  logic [CHAN_W-1:0] lastNext;

  always_comb begin
    if (!cfgMulti || cfgChanCount == '0)
      lastNext = '0;
    else if (cfgChanCount > (CHAN_W+1)'(MAX_CH))
      lastNext = CHAN_W'(MAX_CH - 1);
    else
      lastNext = CHAN_W'(cfgChanCount - 1'b1);
  end

  logic [WORD_W-1:0] inWord;
  logic [WORD_W-1:0] outWord;
  logic [CHAN_W-1:0] outChan;

  always_comb begin
    if (multiQ) begin
      inWord  = {indexQ, slvRdData[SAMPLE_W-1:0]};
      outWord = WORD_W'(bufRdData[SAMPLE_W-1:0]);
      outChan = bufRdData[WORD_W-1:SAMPLE_W];
    end else begin
      inWord  = slvRdData;
      outWord = bufRdData;
      outChan = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      multiQ    <= 1'b0;
      dirInQ    <= 1'b0;
      lastQ     <= '0;
      indexQ    <= '0;
      bufXfer   <= 1'b0;
      slvStrobe <= 1'b0;
      bufWrData <= '0;
      slvWrData <= '0;
      slvChan   <= '0;
      errFlag   <= 1'b0;
    end else if (cfgLoad) begin
      multiQ    <= cfgMulti;
      dirInQ    <= cfgDirIn;
      lastQ     <= lastNext;
      indexQ    <= '0;
      bufXfer   <= 1'b0;
      slvStrobe <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      bufXfer   <= strobe.fire;
      slvStrobe <= strobe.fire;
      if (strobe.drop) errFlag <= 1'b1;
      if (strobe.fire) begin
        if (dirInQ) begin
          bufWrData <= inWord;
          slvChan   <= indexQ;
        end else begin
          slvWrData <= outWord;
          slvChan   <= outChan;
        end
        indexQ <= (indexQ == lastQ) ? '0 : indexQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xferPacer.sv
module xferPacer
  import pacer_pkg::*;
#(
  parameter  int DIV_W       = 24,
  parameter  int SYNC_STAGES = 2,
  parameter  int WORD_W      = 16,
  parameter  int SAMPLE_W    = 12,
  localparam int CHAN_W      = WORD_W - SAMPLE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [1:0]        cfgMode,
  input  logic [DIV_W-1:0]  cfgDivisor,
  input  logic [CHAN_W:0]   cfgChanCount,
  input  logic              cfgMulti,
  input  logic              cfgDirIn,
  input  logic              extClk,
  input  logic              slvReq,
  input  logic              slvStatus,
  output logic              slvPoll,
  input  logic              bufReady,
  input  logic [WORD_W-1:0] bufRdData,
  output logic              bufXfer,
  output logic [WORD_W-1:0] bufWrData,
  input  logic [WORD_W-1:0] slvRdData,
  output logic [WORD_W-1:0] slvWrData,
  output logic [CHAN_W-1:0] slvChan,
  output logic              slvStrobe,
  output logic              errFlag
);
  paceStrobe_t strobe;

  pacerCtl #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgLoad   (cfgLoad),
    .cfgMode   (cfgMode),
    .cfgDivisor(cfgDivisor),
    .extClk    (extClk),
    .slvReq    (slvReq),
    .slvStatus (slvStatus),
    .bufReady  (bufReady),
    .slvPoll   (slvPoll),
    .strobe    (strobe)
  );

  pacerDp #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cfgLoad     (cfgLoad),
    .cfgMulti    (cfgMulti),
    .cfgDirIn    (cfgDirIn),
    .cfgChanCount(cfgChanCount),
    .strobe      (strobe),
    .bufRdData   (bufRdData),
    .slvRdData   (slvRdData),
    .bufXfer     (bufXfer),
    .bufWrData   (bufWrData),
    .slvStrobe   (slvStrobe),
    .slvWrData   (slvWrData),
    .slvChan     (slvChan),
    .errFlag     (errFlag)
  );
endmodule

// File: rtl/xferPacer_chk.sv
module xferPacer_chk #(
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic              bufReady,
  input logic              bufXfer,
  input logic              slvPoll,
  input logic              errFlag,
  input logic [CHAN_W-1:0] slvChan
);
  logic cfgSeen;
  always_ff @(posedge clk) begin
    if (!rstN)        cfgSeen <= 1'b0;
    else if (cfgLoad) cfgSeen <= 1'b1;
  end

  // R5: a transfer strobe only follows a cycle with the buffer ready
  p_ready_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufXfer |-> $past(bufReady));

  // R5: the error flag holds until a reload
  p_sticky_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !cfgLoad) |=> errFlag);

  // R4: poll strobes never occur in consecutive cycles
  p_poll_alternate_r4: assert property (@(posedge clk) disable iff (!rstN)
    slvPoll |=> !slvPoll);

  // R10: a reload leaves a quiet cycle with the error cleared
  p_load_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (!bufXfer && !errFlag));

  // R10: nothing happens before the first configuration
  p_idle_unconfigured_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSeen |-> (!bufXfer && !slvPoll && !errFlag));

  // R8: the channel select only moves together with a transfer
  p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !bufXfer |-> $stable(slvChan));
endmodule

bind xferPacer xferPacer_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgLoad (cfgLoad),
  .bufReady(bufReady),
  .bufXfer (bufXfer),
  .slvPoll (slvPoll),
  .errFlag (errFlag),
  .slvChan (slvChan)
);

// File: tb/xferPacer_tb.sv
module xferPacer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 24;
  localparam int WORD_W     = 16;
  localparam int SAMPLE_W   = 12;
  localparam int CHAN_W     = WORD_W - SAMPLE_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgLoad = 1'b0;
  logic [1:0]        cfgMode = '0;
  logic [DIV_W-1:0]  cfgDivisor = '0;
  logic [CHAN_W:0]   cfgChanCount = '0;
  logic              cfgMulti = 1'b0;
  logic              cfgDirIn = 1'b0;
  logic              extClk = 1'b0;
  logic              slvReq = 1'b0;
  logic              slvStatus = 1'b0;
  logic              slvPoll;
  logic              bufReady = 1'b0;
  logic [WORD_W-1:0] bufRdData = '0;
  logic              bufXfer;
  logic [WORD_W-1:0] bufWrData;
  logic [WORD_W-1:0] slvRdData = '0;
  logic [WORD_W-1:0] slvWrData;
  logic [CHAN_W-1:0] slvChan;
  logic              slvStrobe;
  logic              errFlag;

  xferPacer #(.DIV_W(DIV_W), .WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMode(cfgMode),
    .cfgDivisor(cfgDivisor), .cfgChanCount(cfgChanCount), .cfgMulti(cfgMulti),
    .cfgDirIn(cfgDirIn), .extClk(extClk), .slvReq(slvReq), .slvStatus(slvStatus),
    .slvPoll(slvPoll), .bufReady(bufReady), .bufRdData(bufRdData),
    .bufXfer(bufXfer), .bufWrData(bufWrData), .slvRdData(slvRdData),
    .slvWrData(slvWrData), .slvChan(slvChan), .slvStrobe(slvStrobe),
    .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] expInWord(bit multi, logic [CHAN_W-1:0] ch, logic [WORD_W-1:0] s);
    return multi ? {ch, s[SAMPLE_W-1:0]} : s;
  endfunction

  function automatic logic [WORD_W-1:0] expOutWord(bit multi, logic [WORD_W-1:0] b);
    return multi ? WORD_W'(b[SAMPLE_W-1:0]) : b;
  endfunction

  function automatic int lastChan(bit multi, int count);
    if (!multi || count == 0) return 0;
    if (count > 16) return 15;
    return count - 1;
  endfunction

  task automatic quiet(input int n);
    extClk = 0; slvReq = 0; slvStatus = 0; bufReady = 0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic runMode(input int mode, input int div, input bit multi, input bit dirIn,
                         input int count, input int cycles, input bit randRdy);
    int idx = 0;
    int last = lastChan(multi, count);
    bit errExp = 0;
    bit ex0 = 0, ex1 = 0, ex2 = 0, ex3 = 0;
    bit rq0 = 0, rq1 = 0, rq2 = 0, rq3 = 0;
    bit pExt, pReq, pStat, pRdy;
    logic [WORD_W-1:0] pSlv, pBuf;
    string modeTag;
    modeTag = (mode == 0) ? "R1" : (mode == 1) ? "R2" : (mode == 2) ? "R3" : "R4";

    @(negedge clk);
    cfgMode = 2'(mode); cfgDivisor = DIV_W'(div); cfgMulti = multi;
    cfgDirIn = dirIn; cfgChanCount = (CHAN_W+1)'(count); cfgLoad = 1;
    @(negedge clk);
    cfgLoad = 0;
    chk(bufXfer == 0, "R10 no strobe after load", 32'(bufXfer), 0);
    chk(errFlag == 0, "R10 error cleared by load", 32'(errFlag), 0);

    pExt = 1'($urandom); pReq = 1'($urandom); pStat = 1'($urandom);
    pRdy = randRdy ? ($urandom % 4 != 0) : 1'b1;
    pSlv = WORD_W'($urandom); pBuf = WORD_W'($urandom);
    extClk = pExt; slvReq = pReq; slvStatus = pStat; bufReady = pRdy;
    slvRdData = pSlv; bufRdData = pBuf;

    for (int e = 1; e <= cycles; e++) begin
      bit ev, fire;
      @(negedge clk);
      ex3 = ex2; ex2 = ex1; ex1 = ex0; ex0 = pExt;
      rq3 = rq2; rq2 = rq1; rq1 = rq0; rq0 = pReq;
      case (mode)
        0:       ev = (e >= div + 2) && ((e - div - 2) % (div + 1) == 0);
        1:       ev = ex2 && !ex3;
        2:       ev = rq2 && !rq3;
        default: ev = (e % 2 == 0) && pStat;
      endcase
      fire = ev && pRdy;
      if (ev && !pRdy) errExp = 1;

      chk(bufXfer == fire, {modeTag, " buffer strobe"}, 32'(bufXfer), 32'(fire));
      chk(slvStrobe == fire, {modeTag, " slave strobe"}, 32'(slvStrobe), 32'(fire));
      chk(errFlag == errExp, "R5 sticky error", 32'(errFlag), 32'(errExp));
      chk(slvPoll == (mode == 3 && e % 2 == 0), "R4 poll cadence", 32'(slvPoll),
          32'(mode == 3 && e % 2 == 0));

      if (fire) begin
        if (dirIn) begin
          chk(bufWrData == expInWord(multi, CHAN_W'(idx), pSlv), multi ? "R6 packed word" : "R9 input word",
              32'(bufWrData), 32'(expInWord(multi, CHAN_W'(idx), pSlv)));
          chk(slvChan == (multi ? CHAN_W'(idx) : '0), multi ? "R8 channel index" : "R9 channel zero",
              32'(slvChan), 32'(multi ? idx : 0));
        end else begin
          chk(slvWrData == expOutWord(multi, pBuf), multi ? "R7 unpacked sample" : "R9 output word",
              32'(slvWrData), 32'(expOutWord(multi, pBuf)));
          chk(slvChan == (multi ? pBuf[WORD_W-1:SAMPLE_W] : '0), multi ? "R7 channel tag" : "R9 channel zero",
              32'(slvChan), 32'(multi ? pBuf[WORD_W-1:SAMPLE_W] : 4'd0));
        end
        idx = (idx == last) ? 0 : idx + 1;
      end

      pExt = 1'($urandom); pReq = 1'($urandom); pStat = 1'($urandom);
      pRdy = randRdy ? ($urandom % 4 != 0) : 1'b1;
      pSlv = WORD_W'($urandom); pBuf = WORD_W'($urandom);
      extClk = pExt; slvReq = pReq; slvStatus = pStat; bufReady = pRdy;
      slvRdData = pSlv; bufRdData = pBuf;
    end
    quiet(5);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0;
    quiet(5);
    chk(bufXfer == 0 && slvStrobe == 0, "R10 reset strobes", 32'(bufXfer), 0);
    chk(slvPoll == 0 && errFlag == 0, "R10 reset poll/error", 32'({slvPoll, errFlag}), 0);
    rstN = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(bufXfer == 0 && slvPoll == 0, "R10 idle before config", 32'({bufXfer, slvPoll}), 0);
      extClk = 1'($urandom); slvReq = 1'($urandom); slvStatus = 1'($urandom); bufReady = 1;
    end
    quiet(5);

    runMode(0, 3, 0, 0, 1, 40, 0);     // R1 R9 timer passthrough
    runMode(0, 0, 1, 1, 3, 60, 1);     // R1 R5 R6 R8 every-cycle timer with drops
    runMode(1, 0, 1, 1, 16, 120, 0);   // R2 R6 R8 full 16-channel wrap
    runMode(1, 0, 1, 1, 31, 60, 1);    // R8 count clamp to 16
    runMode(2, 0, 1, 0, 5, 80, 1);     // R3 R7 demand unpack
    runMode(3, 0, 0, 1, 1, 60, 1);     // R4 R9 polled input
    runMode(0, 2, 1, 1, 0, 40, 0);     // R8 count 0 acts as 1
    for (int k = 0; k < 8; k++)
      runMode(int'($urandom % 4), int'($urandom % 6), 1'($urandom), 1'($urandom),
              int'($urandom % 21), 50, 1'($urandom));

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule